// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache with Write-Through

This block is a small cache for a processor port. Every set holds two one-word lines, and each line carries a valid flag, a tag and one data word. A request is looked up in the cycle it is presented. The set index comes from the word address, and the tags of both ways are compared at the same time. When a read hits, a two-input multiplexer that follows the match returns the data of the matching way in that same cycle.

When a read misses, the cache raises a stall and asks the next memory level for the word. When the word comes back, the cache answers the requester and installs the line in the same cycle. The line goes into an empty way of the set if there is one. If both ways are full, it replaces the way that was referenced less recently, which is tracked by a single bit per set. Writes are always passed through to the next level in the cycle they are accepted. A write that hits also updates the cached word, and a write that misses does not allocate a line.

Top module: `twoway_cache`

## Requirements
- R1: After reset every line is invalid and stall and respValid are low, so the first read of any address misses.
- R2: The set is the word address modulo SETS, taken from reqAddr[OFF_W +: IDX_W] where OFF_W = log2(DATA_W/8). Two blocks that map to the same set are held at once, one in each way. With SETS=2 the word sequence 0,4,0,4,0,4,0,4 gives exactly 2 misses.
- R3: A read hit asserts respValid with the cached word in the same cycle as the request and does not raise stall.
- R4: A read miss gives respValid low in the request cycle. From the next cycle, stall and memRdReq stay high until memRdValid arrives, and memRdAddr is the request address with the byte-offset bits forced to zero.
- R5: In the cycle memRdValid is high while stalled, respValid is high and respRdata equals memRdData. Stall is low from the next cycle, and a later read of the same word hits.
- R6: A miss fills an invalid way of the set, if one exists, before any valid line is evicted.
- R7: When both ways are valid, a miss replaces the way not referenced most recently. Hits and fills both count as references.
- R8: Every accepted write raises memWrValid in the same cycle, with memWrAddr equal to reqAddr and memWrData equal to reqWdata, and it never stalls. A write hit updates the cached word, and a write miss leaves the set unchanged.
- R9: Requests presented while stall is high are ignored. They produce no memWrValid and no response.
- R10: The byte-offset bits do not take part in the lookup, so any byte address within a cached word hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | DATA_W | Write data |
| respValid | output | 1 | Read data valid |
| respRdata | output | DATA_W | Read data |
| stall | output | 1 | Miss in progress; requests ignored |
| memRdReq | output | 1 | Line fetch request to next level |
| memRdAddr | output | ADDR_W | Word-aligned fetch address |
| memRdValid | input | 1 | Fetch data returned |
| memRdData | input | DATA_W | Fetch data |
| memWrValid | output | 1 | Write-through strobe |
| memWrAddr | output | ADDR_W | Write-through address |
| memWrData | output | DATA_W | Write-through data |

## Verification
A read hit, the write-through strobe and the fill response are all combinational in their request cycle. The bench therefore changes inputs just after a rising edge and samples at the following falling edge of the same cycle. Stall and memRdReq come from the state register, so they are checked one cycle after a missing read. The stall release is checked one cycle after the fill cycle. Misses and hits are predicted in the stimulus table from the set mapping and the replacement rule. Read data is predicted from a memory model in the bench.

// File: rtl/twoway_cache_pkg.sv
package twoway_cache_pkg;
  // Strobes from the control to the datapath.
  typedef struct packed {
    logic lookup;  // request accepted this cycle
    logic fill;    // fetched word arrives this cycle
  } cacheStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } cacheState_t;
endpackage

// File: rtl/twoway_cache_ctrl.sv
module twoway_cache_ctrl
  import twoway_cache_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic          hit,
  input  logic          memRdValid,
  output cacheStrobes_t strobes,
  output logic          stall,
  output logic          respValid,
  output logic          useFillData,
  output logic          memWrValid
);
  cacheState_t state, stateNext;

  always_comb begin
    strobes.lookup = (state == ST_IDLE) && reqValid;
    strobes.fill   = (state == ST_FILL) && memRdValid;
    stall          = (state == ST_FILL);
    useFillData    = strobes.fill;
    respValid      = (strobes.lookup && !reqWrite && hit) || strobes.fill;
    memWrValid     = strobes.lookup && reqWrite;
    stateNext      = state;
    if (strobes.lookup && !reqWrite && !hit) stateNext = ST_FILL;
    if (strobes.fill)                        stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/twoway_cache_datapath.sv
module twoway_cache_datapath
  import twoway_cache_pkg::*;
#(
  parameter int LINE_W = 30,
  parameter int DATA_W = 32,
  parameter int SETS   = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  cacheStrobes_t     strobes,
  input  logic              reqWrite,
  input  logic [LINE_W-1:0] reqLine,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdData,
  output logic              hit,
  output logic [DATA_W-1:0] hitData,
  output logic [LINE_W-1:0] missLine
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = LINE_W - IDX_W;
  localparam int WAYS  = 2;

  logic [SETS-1:0]   validQ [WAYS];
  logic [TAG_W-1:0]  tagQ   [WAYS][SETS];
  logic [DATA_W-1:0] dataQ  [WAYS][SETS];
  logic [SETS-1:0]   lruQ;   // way to evict next

  logic [IDX_W-1:0] reqIdx, missIdx;
  logic [TAG_W-1:0] reqTag, missTag;
  logic [WAYS-1:0]  wayMatch;
  logic             hitWay, victimWay;

  assign reqIdx  = reqLine[IDX_W-1:0];
  assign reqTag  = reqLine[LINE_W-1:IDX_W];
  assign missIdx = missLine[IDX_W-1:0];
  assign missTag = missLine[LINE_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign wayMatch[w] = validQ[w][reqIdx] && (tagQ[w][reqIdx] == reqTag);
  end

  assign hit     = |wayMatch;
  assign hitWay  = wayMatch[1];
  assign hitData = hitWay ? dataQ[1][reqIdx] : dataQ[0][reqIdx];

  always_comb begin
    if (!validQ[0][missIdx])      victimWay = 1'b0;
    else if (!validQ[1][missIdx]) victimWay = 1'b1;
    else                          victimWay = lruQ[missIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < WAYS; w++) validQ[w] <= '0;
      lruQ <= '0;
    end else begin
      if (strobes.lookup && hit) lruQ[reqIdx] <= ~hitWay;
      if (strobes.fill) begin
        validQ[victimWay][missIdx] <= 1'b1;
        lruQ[missIdx]              <= ~victimWay;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.lookup) missLine <= reqLine;
    if (strobes.lookup && reqWrite && hit) dataQ[hitWay][reqIdx] <= reqWdata;
    if (strobes.fill) begin
      tagQ[victimWay][missIdx]  <= missTag;
      dataQ[victimWay][missIdx] <= memRdData;
    end
  end
endmodule

// File: rtl/twoway_cache.sv
module twoway_cache
  import twoway_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              respValid,
  output logic [DATA_W-1:0] respRdata,
  output logic              stall,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdValid,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrValid,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData
);
  localparam int OFF_W  = $clog2(DATA_W / 8);
  localparam int LINE_W = ADDR_W - OFF_W;

  cacheStrobes_t     strobes;
  logic              hit, useFillData;
  logic [DATA_W-1:0] hitData;
  logic [LINE_W-1:0] missLine;

  twoway_cache_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .hit(hit), .memRdValid(memRdValid), .strobes(strobes), .stall(stall),
    .respValid(respValid), .useFillData(useFillData), .memWrValid(memWrValid)
  );

  twoway_cache_datapath #(.LINE_W(LINE_W), .DATA_W(DATA_W), .SETS(SETS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqWrite(reqWrite),
    .reqLine(reqAddr[ADDR_W-1:OFF_W]), .reqWdata(reqWdata),
    .memRdData(memRdData), .hit(hit), .hitData(hitData), .missLine(missLine)
  );

  assign respRdata = useFillData ? memRdData : hitData;
  assign memRdReq  = stall;
  assign memRdAddr = {missLine, {OFF_W{1'b0}}};
  assign memWrAddr = reqAddr;
  assign memWrData = reqWdata;
endmodule

// File: rtl/twoway_cache_chk.sv
module twoway_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [DATA_W-1:0] reqWdata,
  input logic              respValid,
  input logic [DATA_W-1:0] respRdata,
  input logic              stall,
  input logic              memRdReq,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              memRdValid,
  input logic [DATA_W-1:0] memRdData,
  input logic              memWrValid,
  input logic [ADDR_W-1:0] memWrAddr,
  input logic [DATA_W-1:0] memWrData
);
  // R4: a read that is accepted without an answer starts a fetch
  a_r4_miss_stalls: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !stall && !reqWrite && !respValid) |=> (stall && memRdReq));

  // R4: a pending fetch holds until its data arrives
  a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !memRdValid) |=> (stall && $stable(memRdAddr)));

  // R5: fill data is answered in the same cycle
  a_r5_fill_resp: assert property (@(posedge clk) disable iff (!rstN)
    (stall && memRdValid) |-> (respValid && respRdata == memRdData));

  // R5: stall drops after the fill
  a_r5_release: assert property (@(posedge clk) disable iff (!rstN)
    (stall && memRdValid) |=> !stall);

  // R8: accepted writes go through at once
  a_r8_write_through: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !stall) |->
      (memWrValid && memWrAddr == reqAddr && memWrData == reqWdata && !respValid));

  // R9: nothing is accepted while stalled
  a_r9_ignore_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !memRdValid) |-> (!respValid && !memWrValid));
endmodule

bind twoway_cache twoway_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/twoway_cache_tb.sv
module twoway_cache_tb;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int SETS   = 2;
  localparam int NVEC   = 24;

  // entry: {isWrite, expectHit, wordAddr[5:0]}
  localparam logic [7:0] VEC [NVEC] = '{
    // R2/R6 ping-pong in set 0: both ways filled, then all hits
    {2'b00, 6'd0}, {2'b00, 6'd4}, {2'b01, 6'd0}, {2'b01, 6'd4},
    {2'b01, 6'd0}, {2'b01, 6'd4}, {2'b01, 6'd0}, {2'b01, 6'd4},
    // R7 replacement by recency, hits refresh recency
    {2'b00, 6'd8}, {2'b01, 6'd4}, {2'b00, 6'd0}, {2'b01, 6'd4},
    {2'b00, 6'd8}, {2'b00, 6'd0}, {2'b01, 6'd8}, {2'b00, 6'd4},
    // set 1
    {2'b00, 6'd1}, {2'b00, 6'd3}, {2'b01, 6'd1},
    // R8 write hit then read, write miss then read
    {2'b11, 6'd3}, {2'b01, 6'd3}, {2'b10, 6'd5}, {2'b00, 6'd5},
    {2'b01, 6'd3}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              respValid, stall, memRdReq, memWrValid;
  logic [DATA_W-1:0] respRdata, memWrData;
  logic [ADDR_W-1:0] memRdAddr, memWrAddr;
  logic              memRdValid = 1'b0;
  logic [DATA_W-1:0] memRdData = '0;

  logic [DATA_W-1:0] model [64];
  int checks = 0, fails = 0, misses = 0;
  bit done = 0;

  always #2 clk = ~clk;

  twoway_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] addr, input bit expHit, input string req);
    logic [5:0] w;
    w = addr[7:2];
    @(posedge clk); #1;
    reqValid = 1; reqWrite = 0; reqAddr = addr;
    @(negedge clk);
    check(respValid == expHit, req, respValid, expHit);
    if (expHit) check(respRdata == model[w], "R3", respRdata, model[w]);
    @(posedge clk); #1;
    reqValid = 0;
    if (!expHit) begin
      misses++;
      @(negedge clk);
      check(stall && memRdReq && !respValid, "R4", {stall, memRdReq, respValid}, 3'b110);
      check(memRdAddr == {addr[ADDR_W-1:2], 2'b00}, "R4", memRdAddr, {addr[ADDR_W-1:2], 2'b00});
      memRdValid = 1; memRdData = model[w];
      #1;
      check(respValid && respRdata == model[w], "R5", respRdata, model[w]);
      @(posedge clk); #1;
      memRdValid = 0;
      @(negedge clk);
      check(!stall, "R5", stall, 0);
    end
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] data);
    @(posedge clk); #1;
    reqValid = 1; reqWrite = 1; reqAddr = addr; reqWdata = data;
    @(negedge clk);
    check(memWrValid && memWrAddr == addr && memWrData == data && !stall && !respValid,
          "R8", {memWrValid, memWrData}, {1'b1, data});
    model[addr[7:2]] = data;
    @(posedge clk); #1;
    reqValid = 0; reqWrite = 0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 32'hC0DE0000 + i * 32'h111;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check(!stall && !respValid && !memRdReq, "R1", {stall, respValid}, 0);
    rstN = 1;

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][7]) doWrite({24'd0, VEC[v][5:0], 2'b00}, 32'hA5000000 + v);
      else           doRead({24'd0, VEC[v][5:0], 2'b00}, VEC[v][6], "R7");
      if (v == 7) check(misses == 2, "R2", misses, 2);
      if (v == 1) check(misses == 2, "R6", misses, 2);
    end

    // R10: byte offset ignored
    doRead(32'd3 * 4 + 3, 1'b1, "R10");
    doRead(32'd3 * 4 + 1, 1'b1, "R10");

    // R9: requests during stall ignored
    @(posedge clk); #1;
    reqValid = 1; reqWrite = 0; reqAddr = 32'd12 * 4;
    @(posedge clk); #1;
    reqWrite = 1; reqAddr = 32'd2 * 4; reqWdata = 32'hDEADBEEF;
    @(negedge clk);
    check(stall && !memWrValid && !respValid, "R9", {stall, memWrValid, respValid}, 3'b100);
    @(posedge clk); #1;
    @(negedge clk);
    check(stall && !memWrValid, "R9", {stall, memWrValid}, 2'b10);
    reqValid = 0; reqWrite = 0;
    memRdValid = 1; memRdData = model[12];
    #1;
    check(respValid && respRdata == model[12], "R5", respRdata, model[12]);
    @(posedge clk); #1;
    memRdValid = 0;
    doRead(32'd12 * 4, 1'b1, "R5");
    // word 2 never written: fetch returns the untouched model value
    doRead(32'd2 * 4, 1'b0, "R9");

    // R1: reset clears lines
    @(posedge clk); #1; rstN = 0;
    @(posedge clk); #1; rstN = 1;
    doRead(32'd12 * 4, 1'b0, "R1");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule